// File: doc/BRIEF.md
# Serial Channel Command Decoder

This block sits behind the command register of one serial channel. A write strobe presents one byte to it. The byte's upper four bits hold a single encoded miscellaneous command. Its lower four bits hold independent enable and disable requests for the transmitter and the receiver.

The block turns each accepted write into two kinds of output:
- one-clock action pulses, which drive the receiver, the transmitter, the status logic, the break logic and the counter/timer;
- persistent control levels: the RTS line, transmitter enable, receiver enable, timeout mode and power-down.

One parameter marks the instance as the primary channel. Only that channel honours the power-down entry and exit codes; on a secondary instance both codes do nothing. While power-down is active, the block ignores every write except the exit code.

Top module: `chan_cmd_decoder`

## Requirements
- R1: After reset every pulse output is low, `stat_clr_o` is zero, `rts_n_o` is high, and `tx_en_o`, `rx_en_o`, `tmo_mode_o` and `pd_o` are low.
- R2: An accepted write with upper nibble 0001, 0010, 0011, 0100 or 0101 pulses `ptr_rst_o`, `rx_rst_o`, `tx_rst_o`, `err_clr_o` or `brk_int_clr_o` respectively. The pulse lasts one cycle and appears in the cycle after the strobe. With 0100, `stat_clr_o` equals 8'hF0 for that cycle, so the four error flags in status bits 7 to 4 are cleared together.
- R3: Upper nibble 0110 pulses `brk_start_o` and upper nibble 0111 pulses `brk_stop_o`.
- R4: Upper nibble 1000 drives `rts_n_o` low and upper nibble 1001 drives it high. The level then holds until the next such command.
- R5: Upper nibble 1010 pulses `tmo_set_o` and sets `tmo_mode_o`. Upper nibble 1100 pulses `tmo_clr_o` and clears `tmo_mode_o`. Codes 0000, 1011 and 1101 produce no pulse and change no state.
- R6: In the lower nibble, bit 2 enables the transmitter, bit 3 disables it, bit 0 enables the receiver and bit 1 disables it. These bits act in the same write as the upper-nibble command.
- R7: If one write sets both the enable and the disable bit for the same direction, that direction ends up disabled and `illegal_o` pulses for one cycle.
- R8: A receiver reset (0010) clears `rx_en_o` and a transmitter reset (0011) clears `tx_en_o`. The reset wins over an enable bit in the same write.
- R9: An accepted receiver enable pulses `rx_hunt_o`, which sends the receiver back to its search for a start bit. The pulse is suppressed when `wakeup_i` is high at the write.
- R10: On the primary channel, 1110 pulses `pd_enter_o` and sets `pd_o`, and 1111 pulses `pd_exit_o` and clears `pd_o`.
- R11: While `pd_o` is high, any write whose upper nibble is not 1111 produces no pulse and leaves all state unchanged, lower bits included.
- R12: On a secondary channel (PRIMARY=0), codes 1110 and 1111 produce no pulse and `pd_o` stays low.
- R13: A cycle without a write strobe in the previous cycle produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Command write strobe |
| wdata_i | input | CMD_W | Command byte |
| wakeup_i | input | 1 | Wake-up mode active; suppresses hunt on receiver enable |
| ptr_rst_o | output | 1 | Mode-pointer reset pulse |
| rx_rst_o | output | 1 | Receiver reset pulse |
| tx_rst_o | output | 1 | Transmitter reset pulse |
| err_clr_o | output | 1 | Error-status clear pulse |
| stat_clr_o | output | STAT_W | Status bits to clear this cycle |
| brk_int_clr_o | output | 1 | Break-change interrupt clear pulse |
| brk_start_o | output | 1 | Start-break request pulse |
| brk_stop_o | output | 1 | Stop-break request pulse |
| tmo_set_o | output | 1 | Timeout-mode on pulse |
| tmo_clr_o | output | 1 | Timeout-mode off pulse |
| tmo_mode_o | output | 1 | Timeout mode level |
| pd_enter_o | output | 1 | Power-down entry pulse |
| pd_exit_o | output | 1 | Power-down exit pulse |
| pd_o | output | 1 | Power-down level |
| rts_n_o | output | 1 | RTS output, active low |
| tx_en_o | output | 1 | Transmitter enabled |
| rx_en_o | output | 1 | Receiver enabled |
| rx_hunt_o | output | 1 | Receiver start-bit hunt pulse |
| illegal_o | output | 1 | Conflicting enable/disable pulse |

## Verification
A wrong power-down flag is the costliest internal fault. It silently swallows later writes, so it appears only at the next command, as a missing pulse or an unchanged level. A wrong enable or RTS level stays visible at its port from the cycle after the write that set it. A mis-decoded nibble shows as the wrong pulse exactly one cycle after the strobe. Every write is therefore compared at that cycle and again one cycle later, when all pulses must have dropped. Both a primary and a secondary instance see the same writes.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;

   typedef enum logic [3:0] {
      CMD_NONE        = 4'h0,
      CMD_PTR_RST     = 4'h1,
      CMD_RX_RST      = 4'h2,
      CMD_TX_RST      = 4'h3,
      CMD_ERR_CLR     = 4'h4,
      CMD_BRK_INT_CLR = 4'h5,
      CMD_BRK_START   = 4'h6,
      CMD_BRK_STOP    = 4'h7,
      CMD_RTS_ON      = 4'h8,
      CMD_RTS_OFF     = 4'h9,
      CMD_TMO_ON      = 4'hA,
      CMD_RSV_B       = 4'hB,
      CMD_TMO_OFF     = 4'hC,
      CMD_RSV_D       = 4'hD,
      CMD_PD_ENTER    = 4'hE,
      CMD_PD_EXIT     = 4'hF
   } misc_cmd_e;

   typedef struct packed {
      logic ptr_rst;
      logic rx_rst;
      logic tx_rst;
      logic err_clr;
      logic brk_int_clr;
      logic brk_start;
      logic brk_stop;
      logic rts_on;
      logic rts_off;
      logic tmo_on;
      logic tmo_off;
      logic pd_enter;
      logic pd_exit;
   } misc_act_t;

   typedef struct packed {
      logic tx_on;
      logic tx_off;
      logic rx_on;
      logic rx_off;
      logic illegal;
   } en_req_t;

endpackage

// File: rtl/chan_cmd_misc_dec.sv
module chan_cmd_misc_dec
   import chan_cmd_pkg::*;
#(
   parameter bit PRIMARY = 1'b1
) (
   input  logic      valid_i,
   input  logic [3:0] code_i,
   output misc_act_t act_o
);

   logic pd_en_w;
   logic pd_ex_w;

   generate
      if (PRIMARY) begin : g_pd
         assign pd_en_w = valid_i && (code_i == CMD_PD_ENTER);
         assign pd_ex_w = valid_i && (code_i == CMD_PD_EXIT);
      end else begin : g_no_pd
         assign pd_en_w = 1'b0;
         assign pd_ex_w = 1'b0;
      end
   endgenerate

   always_comb begin
      act_o = '0;
      if (valid_i) begin
         case (misc_cmd_e'(code_i))
            CMD_PTR_RST:     act_o.ptr_rst     = 1'b1;
            CMD_RX_RST:      act_o.rx_rst      = 1'b1;
            CMD_TX_RST:      act_o.tx_rst      = 1'b1;
            CMD_ERR_CLR:     act_o.err_clr     = 1'b1;
            CMD_BRK_INT_CLR: act_o.brk_int_clr = 1'b1;
            CMD_BRK_START:   act_o.brk_start   = 1'b1;
            CMD_BRK_STOP:    act_o.brk_stop    = 1'b1;
            CMD_RTS_ON:      act_o.rts_on      = 1'b1;
            CMD_RTS_OFF:     act_o.rts_off     = 1'b1;
            CMD_TMO_ON:      act_o.tmo_on      = 1'b1;
            CMD_TMO_OFF:     act_o.tmo_off     = 1'b1;
            default:         ;
         endcase
      end
      act_o.pd_enter = pd_en_w;
      act_o.pd_exit  = pd_ex_w;
   end

endmodule

// File: rtl/chan_cmd_en_arb.sv
module chan_cmd_en_arb
   import chan_cmd_pkg::*;
#(
   parameter int TX_ON_BIT  = 2,
   parameter int TX_OFF_BIT = 3,
   parameter int RX_ON_BIT  = 0,
   parameter int RX_OFF_BIT = 1
) (
   input  logic       valid_i,
   input  logic [3:0] bits_i,
   output en_req_t    req_o
);

   logic tx_on_raw, tx_off_raw, rx_on_raw, rx_off_raw;

   assign tx_on_raw  = valid_i && bits_i[TX_ON_BIT];
   assign tx_off_raw = valid_i && bits_i[TX_OFF_BIT];
   assign rx_on_raw  = valid_i && bits_i[RX_ON_BIT];
   assign rx_off_raw = valid_i && bits_i[RX_OFF_BIT];

   // disable wins over enable within one write
   assign req_o.tx_off  = tx_off_raw;
   assign req_o.tx_on   = tx_on_raw && !tx_off_raw;
   assign req_o.rx_off  = rx_off_raw;
   assign req_o.rx_on   = rx_on_raw && !rx_off_raw;
   assign req_o.illegal = (tx_on_raw && tx_off_raw) || (rx_on_raw && rx_off_raw);

endmodule

// File: rtl/chan_cmd_ctrl_regs.sv
module chan_cmd_ctrl_regs
   import chan_cmd_pkg::*;
#(
   parameter int STAT_W    = 8,
   parameter int ERR_LSB   = 4,
   parameter int ERR_W     = 4,
   parameter bit RTS_RST_N = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  misc_act_t         act_i,
   input  en_req_t           req_i,
   input  logic              wakeup_i,
   output logic              ptr_rst_o,
   output logic              rx_rst_o,
   output logic              tx_rst_o,
   output logic              err_clr_o,
   output logic [STAT_W-1:0] stat_clr_o,
   output logic              brk_int_clr_o,
   output logic              brk_start_o,
   output logic              brk_stop_o,
   output logic              tmo_set_o,
   output logic              tmo_clr_o,
   output logic              tmo_mode_o,
   output logic              pd_enter_o,
   output logic              pd_exit_o,
   output logic              pd_o,
   output logic              rts_n_o,
   output logic              tx_en_o,
   output logic              rx_en_o,
   output logic              rx_hunt_o,
   output logic              illegal_o
);

   localparam logic [STAT_W-1:0] ERR_MASK = STAT_W'(((1 << ERR_W) - 1) << ERR_LSB);

   logic tx_d, rx_d, pd_d, tmo_d, rts_d, hunt_d;

   always_comb begin
      tx_d = tx_en_o;
      if (act_i.tx_rst || req_i.tx_off) tx_d = 1'b0;
      else if (req_i.tx_on)             tx_d = 1'b1;

      rx_d = rx_en_o;
      if (act_i.rx_rst || req_i.rx_off) rx_d = 1'b0;
      else if (req_i.rx_on)             rx_d = 1'b1;

      hunt_d = req_i.rx_on && !act_i.rx_rst && !wakeup_i;

      pd_d = pd_o;
      if (act_i.pd_enter)     pd_d = 1'b1;
      else if (act_i.pd_exit) pd_d = 1'b0;

      tmo_d = tmo_mode_o;
      if (act_i.tmo_on)       tmo_d = 1'b1;
      else if (act_i.tmo_off) tmo_d = 1'b0;

      rts_d = rts_n_o;
      if (act_i.rts_on)       rts_d = 1'b0;
      else if (act_i.rts_off) rts_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_rst_o     <= 1'b0;
         rx_rst_o      <= 1'b0;
         tx_rst_o      <= 1'b0;
         err_clr_o     <= 1'b0;
         stat_clr_o    <= '0;
         brk_int_clr_o <= 1'b0;
         brk_start_o   <= 1'b0;
         brk_stop_o    <= 1'b0;
         tmo_set_o     <= 1'b0;
         tmo_clr_o     <= 1'b0;
         pd_enter_o    <= 1'b0;
         pd_exit_o     <= 1'b0;
         rx_hunt_o     <= 1'b0;
         illegal_o     <= 1'b0;
         tmo_mode_o    <= 1'b0;
         pd_o          <= 1'b0;
         rts_n_o       <= RTS_RST_N;
         tx_en_o       <= 1'b0;
         rx_en_o       <= 1'b0;
      end else begin
         ptr_rst_o     <= act_i.ptr_rst;
         rx_rst_o      <= act_i.rx_rst;
         tx_rst_o      <= act_i.tx_rst;
         err_clr_o     <= act_i.err_clr;
         stat_clr_o    <= act_i.err_clr ? ERR_MASK : '0;
         brk_int_clr_o <= act_i.brk_int_clr;
         brk_start_o   <= act_i.brk_start;
         brk_stop_o    <= act_i.brk_stop;
         tmo_set_o     <= act_i.tmo_on;
         tmo_clr_o     <= act_i.tmo_off;
         pd_enter_o    <= act_i.pd_enter;
         pd_exit_o     <= act_i.pd_exit;
         rx_hunt_o     <= hunt_d;
         illegal_o     <= req_i.illegal;
         tmo_mode_o    <= tmo_d;
         pd_o          <= pd_d;
         rts_n_o       <= rts_d;
         tx_en_o       <= tx_d;
         rx_en_o       <= rx_d;
      end
   end

endmodule

// File: rtl/chan_cmd_decoder.sv
module chan_cmd_decoder
   import chan_cmd_pkg::*;
#(
   parameter int CMD_W     = 8,
   parameter int STAT_W    = 8,
   parameter int ERR_LSB   = 4,
   parameter int ERR_W     = 4,
   parameter bit PRIMARY   = 1'b1,
   parameter bit RTS_RST_N = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [CMD_W-1:0]  wdata_i,
   input  logic              wakeup_i,
   output logic              ptr_rst_o,
   output logic              rx_rst_o,
   output logic              tx_rst_o,
   output logic              err_clr_o,
   output logic [STAT_W-1:0] stat_clr_o,
   output logic              brk_int_clr_o,
   output logic              brk_start_o,
   output logic              brk_stop_o,
   output logic              tmo_set_o,
   output logic              tmo_clr_o,
   output logic              tmo_mode_o,
   output logic              pd_enter_o,
   output logic              pd_exit_o,
   output logic              pd_o,
   output logic              rts_n_o,
   output logic              tx_en_o,
   output logic              rx_en_o,
   output logic              rx_hunt_o,
   output logic              illegal_o
);

   localparam int NIB_W = CMD_W / 2;

   generate
      if (CMD_W != 8) begin : g_bad_cmd_w
         $error("chan_cmd_decoder: CMD_W must be 8");
      end
      if (ERR_LSB + ERR_W > STAT_W) begin : g_bad_err_field
         $error("chan_cmd_decoder: error field exceeds status width");
      end
   endgenerate

   logic [NIB_W-1:0] code_w;
   logic [NIB_W-1:0] bits_w;
   logic             misc_valid;
   logic             en_valid;
   misc_act_t        act_w;
   en_req_t          req_w;

   assign code_w = wdata_i[CMD_W-1:NIB_W];
   assign bits_w = wdata_i[NIB_W-1:0];

   // power-down lets only the exit code through
   assign misc_valid = wr_i && (!pd_o || (code_w == CMD_PD_EXIT));
   assign en_valid   = wr_i && !pd_o;

   chan_cmd_misc_dec #(.PRIMARY(PRIMARY)) u_misc (
      .valid_i (misc_valid),
      .code_i  (code_w),
      .act_o   (act_w)
   );

   chan_cmd_en_arb u_arb (
      .valid_i (en_valid),
      .bits_i  (bits_w),
      .req_o   (req_w)
   );

   chan_cmd_ctrl_regs #(
      .STAT_W    (STAT_W),
      .ERR_LSB   (ERR_LSB),
      .ERR_W     (ERR_W),
      .RTS_RST_N (RTS_RST_N)
   ) u_regs (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .act_i         (act_w),
      .req_i         (req_w),
      .wakeup_i      (wakeup_i),
      .ptr_rst_o     (ptr_rst_o),
      .rx_rst_o      (rx_rst_o),
      .tx_rst_o      (tx_rst_o),
      .err_clr_o     (err_clr_o),
      .stat_clr_o    (stat_clr_o),
      .brk_int_clr_o (brk_int_clr_o),
      .brk_start_o   (brk_start_o),
      .brk_stop_o    (brk_stop_o),
      .tmo_set_o     (tmo_set_o),
      .tmo_clr_o     (tmo_clr_o),
      .tmo_mode_o    (tmo_mode_o),
      .pd_enter_o    (pd_enter_o),
      .pd_exit_o     (pd_exit_o),
      .pd_o          (pd_o),
      .rts_n_o       (rts_n_o),
      .tx_en_o       (tx_en_o),
      .rx_en_o       (rx_en_o),
      .rx_hunt_o     (rx_hunt_o),
      .illegal_o     (illegal_o)
   );

endmodule

// File: rtl/chan_cmd_checker.sv
module chan_cmd_checker #(
   parameter int CMD_W   = 8,
   parameter int STAT_W  = 8,
   parameter bit PRIMARY = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_i,
   input logic [CMD_W-1:0]  wdata_i,
   input logic              ptr_rst_o,
   input logic              rx_rst_o,
   input logic              tx_rst_o,
   input logic              err_clr_o,
   input logic [STAT_W-1:0] stat_clr_o,
   input logic              brk_int_clr_o,
   input logic              brk_start_o,
   input logic              brk_stop_o,
   input logic              tmo_set_o,
   input logic              tmo_clr_o,
   input logic              tmo_mode_o,
   input logic              pd_enter_o,
   input logic              pd_exit_o,
   input logic              pd_o,
   input logic              rts_n_o,
   input logic              tx_en_o,
   input logic              rx_en_o,
   input logic              rx_hunt_o,
   input logic              illegal_o
);

   logic [10:0] misc_p;
   logic        any_p;

   assign misc_p = {ptr_rst_o, rx_rst_o, tx_rst_o, err_clr_o, brk_int_clr_o,
                    brk_start_o, brk_stop_o, tmo_set_o, tmo_clr_o,
                    pd_enter_o, pd_exit_o};
   assign any_p  = (|misc_p) || rx_hunt_o || illegal_o;

   assert_pulse_after_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_p |-> $past(wr_i));

   assert_single_misc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(misc_p));

   assert_err_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_clr_o |-> ($countones(stat_clr_o) == 4 && stat_clr_o[7:4] == 4'hF));

   assert_rts_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(wr_i) |-> $stable(rts_n_o));

   assert_conflict_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !pd_o && wdata_i[3] && wdata_i[2]) |=> (!tx_en_o && illegal_o));

   assert_hunt_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_hunt_o |-> rx_en_o);

   assert_pd_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pd_o && wr_i && wdata_i[7:4] != 4'hF) |=>
         (pd_o && !any_p && $stable({rts_n_o, tx_en_o, rx_en_o, tmo_mode_o})));

   generate
      if (!PRIMARY) begin : g_sec
         assert_no_pd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !pd_o && !pd_enter_o && !pd_exit_o);
      end
   endgenerate

endmodule

bind chan_cmd_decoder chan_cmd_checker #(
   .CMD_W   (CMD_W),
   .STAT_W  (STAT_W),
   .PRIMARY (PRIMARY)
) u_chk (.*);

// File: tb/chan_cmd_decoder_tb.sv
`timescale 1ns/1ps
module chan_cmd_decoder_tb;

   typedef struct packed {
      logic rts_n;
      logic tx;
      logic rx;
      logic pd;
      logic tmo;
   } st_t;

   // p: [12]ptr [11]rxr [10]txr [9]err [8]brkint [7]bstart [6]bstop
   //    [5]tset [4]tclr [3]pdent [2]pdex [1]hunt [0]illegal
   typedef struct packed {
      logic [12:0] p;
      logic [7:0]  mask;
      st_t         s;
   } obs_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       wake = 1'b0;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   logic a_ptr, a_rxr, a_txr, a_err, a_bint, a_bst, a_bsp, a_ts, a_tc, a_tm, a_pe, a_px, a_pd, a_rts, a_tx, a_rx, a_hunt, a_ill;
   logic b_ptr, b_rxr, b_txr, b_err, b_bint, b_bst, b_bsp, b_ts, b_tc, b_tm, b_pe, b_px, b_pd, b_rts, b_tx, b_rx, b_hunt, b_ill;
   logic [7:0] a_stat, b_stat;
   obs_t obs_a, obs_b;

   chan_cmd_decoder #(.PRIMARY(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .wakeup_i(wake),
      .ptr_rst_o(a_ptr), .rx_rst_o(a_rxr), .tx_rst_o(a_txr), .err_clr_o(a_err),
      .stat_clr_o(a_stat), .brk_int_clr_o(a_bint), .brk_start_o(a_bst),
      .brk_stop_o(a_bsp), .tmo_set_o(a_ts), .tmo_clr_o(a_tc), .tmo_mode_o(a_tm),
      .pd_enter_o(a_pe), .pd_exit_o(a_px), .pd_o(a_pd), .rts_n_o(a_rts),
      .tx_en_o(a_tx), .rx_en_o(a_rx), .rx_hunt_o(a_hunt), .illegal_o(a_ill));

   chan_cmd_decoder #(.PRIMARY(1'b0)) u_dut_b (
      .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .wakeup_i(wake),
      .ptr_rst_o(b_ptr), .rx_rst_o(b_rxr), .tx_rst_o(b_txr), .err_clr_o(b_err),
      .stat_clr_o(b_stat), .brk_int_clr_o(b_bint), .brk_start_o(b_bst),
      .brk_stop_o(b_bsp), .tmo_set_o(b_ts), .tmo_clr_o(b_tc), .tmo_mode_o(b_tm),
      .pd_enter_o(b_pe), .pd_exit_o(b_px), .pd_o(b_pd), .rts_n_o(b_rts),
      .tx_en_o(b_tx), .rx_en_o(b_rx), .rx_hunt_o(b_hunt), .illegal_o(b_ill));

   assign obs_a = {a_ptr, a_rxr, a_txr, a_err, a_bint, a_bst, a_bsp, a_ts, a_tc, a_pe, a_px, a_hunt, a_ill,
                   a_stat, a_rts, a_tx, a_rx, a_pd, a_tm};
   assign obs_b = {b_ptr, b_rxr, b_txr, b_err, b_bint, b_bst, b_bsp, b_ts, b_tc, b_pe, b_px, b_hunt, b_ill,
                   b_stat, b_rts, b_tx, b_rx, b_pd, b_tm};

   st_t st_a, st_b;

   function automatic obs_t model(input st_t s, input logic [7:0] d, input logic wk,
                                  input bit prim, output st_t ns);
      obs_t o;
      logic [3:0] hi;
      hi = d[7:4];
      ns = s;
      o  = '0;
      if (s.pd) begin
         if (prim && hi == 4'hF) begin ns.pd = 1'b0; o.p[2] = 1'b1; end
      end else begin
         case (hi)
            4'h1: o.p[12] = 1'b1;
            4'h2: o.p[11] = 1'b1;
            4'h3: o.p[10] = 1'b1;
            4'h4: begin o.p[9] = 1'b1; o.mask = 8'hF0; end
            4'h5: o.p[8] = 1'b1;
            4'h6: o.p[7] = 1'b1;
            4'h7: o.p[6] = 1'b1;
            4'h8: ns.rts_n = 1'b0;
            4'h9: ns.rts_n = 1'b1;
            4'hA: begin o.p[5] = 1'b1; ns.tmo = 1'b1; end
            4'hC: begin o.p[4] = 1'b1; ns.tmo = 1'b0; end
            4'hE: if (prim) begin o.p[3] = 1'b1; ns.pd = 1'b1; end
            4'hF: if (prim) begin o.p[2] = 1'b1; ns.pd = 1'b0; end
            default: ;
         endcase
         if (hi == 4'h3 || d[3]) ns.tx = 1'b0;
         else if (d[2])          ns.tx = 1'b1;
         if (hi == 4'h2 || d[1]) ns.rx = 1'b0;
         else if (d[0]) begin
            ns.rx = 1'b1;
            o.p[1] = !wk;
         end
         o.p[0] = (d[3] && d[2]) || (d[1] && d[0]);
      end
      o.s = ns;
      return o;
   endfunction

   function automatic string tag_of(input st_t s, input logic [7:0] d, input bit prim);
      logic [3:0] hi;
      hi = d[7:4];
      if (s.pd) return "R11";
      if ((d[3] && d[2]) || (d[1] && d[0])) return "R7";
      if ((hi == 4'h2 || hi == 4'h3) && d[3:0] != 0) return "R8";
      if (d[0]) return "R9";
      if (d[3:0] != 0) return "R6";
      case (hi)
         4'h1, 4'h2, 4'h3, 4'h4, 4'h5: return "R2";
         4'h6, 4'h7: return "R3";
         4'h8, 4'h9: return "R4";
         4'hE, 4'hF: return prim ? "R10" : "R12";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string tag, input obs_t act, input obs_t exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d, input logic wk);
      obs_t ea, eb, ia, ib;
      st_t na, nb;
      string ta, tb;
      @(negedge clk);
      wr = 1'b1; wdata = d; wake = wk;
      ea = model(st_a, d, wk, 1'b1, na);
      eb = model(st_b, d, wk, 1'b0, nb);
      ta = tag_of(st_a, d, 1'b1);
      tb = tag_of(st_b, d, 1'b0);
      @(negedge clk);
      wr = 1'b0;
      check(ta, obs_a, ea);
      check(tb, obs_b, eb);
      st_a = na; st_b = nb;
      @(negedge clk);
      ia = '0; ia.s = st_a;
      ib = '0; ib.s = st_b;
      check("R13", obs_a, ia);
      check("R13", obs_b, ib);
   endtask

   initial begin
      obs_t r;
      int unsigned rv;
      st_a = '{rts_n: 1'b1, tx: 1'b0, rx: 1'b0, pd: 1'b0, tmo: 1'b0};
      st_b = st_a;
      rv = $urandom(32'd1729);
      repeat (3) @(negedge clk);
      r = '0; r.s = st_a;
      check("R1", obs_a, r);
      check("R1", obs_b, r);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", obs_a, r);
      // every upper-nibble code alone (pd codes revisited below)
      for (int c = 0; c < 14; c++) do_write({c[3:0], 4'h0}, 1'b0);
      // lower bits R6, conflicts R7, reset priority R8, hunt R9
      do_write(8'h05, 1'b0);
      do_write(8'h0A, 1'b0);
      do_write(8'h0F, 1'b0);
      do_write(8'h05, 1'b0);
      do_write(8'h34, 1'b0);
      do_write(8'h21, 1'b0);
      do_write(8'h01, 1'b1);
      do_write(8'h8C, 1'b0);
      // RTS hold R4 across idle cycles
      repeat (4) @(negedge clk);
      r = '0; r.s = st_a;
      check("R4", obs_a, r);
      // power-down R10/R11/R12
      do_write(8'hE5, 1'b0);
      do_write(8'h95, 1'b0);
      do_write(8'h4A, 1'b0);
      do_write(8'hEF, 1'b0);
      do_write(8'hF0, 1'b0);
      do_write(8'hF0, 1'b0);
      // random traffic
      for (int i = 0; i < 600; i++) begin
         rv = $urandom;
         do_write(rv[7:0], rv[9:8] == 2'b00);
         if (rv[12:10] == 3'b000) @(negedge clk);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule